// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block collects a parameterised set of level-sensitive peripheral interrupt lines (32, 64 or 128) and presents one interrupt request to each of one or two processor cores. Every core owns a private register window that holds an enable mask for all inputs and a read-only view of the masked pending state. Because the masks are independent, software steers any peripheral line to core 0, to core 1, to both, or to neither.

Inputs are taken through a two-stage synchroniser. They are then ANDed with a core's enable mask to form that core's status words. A core's interrupt output is the registered OR of its status bits. There is no priority encoder and no pending queue, so the interrupt handler reads every status word of its window to find the active sources. Access goes over a simple synchronous word bus. Read data is registered and appears one cycle after the request.

Top module: `pirq_agg`

## Requirements
- R1: After reset every enable word is zero, both core interrupt outputs are low, and every mapped word reads back as zero.
- R2: The bus word address is {window, offset[2:0]}, with window = busAddr[3] selecting the core. With G = NUM_IRQ/32 groups, the enable words occupy offsets 0..G-1. Offset k holds inputs of group G-1-k, so the highest group sits at offset 0. A write replaces the whole 32-bit word, and a read returns the value last written.
- R3: The status words occupy offsets G..2G-1 with the same group order as the enable words, so offset G+k covers group G-1-k. A status bit reads as the synchronised input ANDed with that core's enable bit.
- R4: Writes to status offsets change no enable bit and no status bit.
- R5: A core's interrupt output is high exactly when any of its status bits is set. An input that rises while it is enabled raises the output on the third clock edge after the input changes.
- R6: A core's interrupt output falls on the clock edge after its enable is cleared. It falls on the third edge after the enabled input drops.
- R7: A write to one core's window leaves the other core's enables and interrupt routing unchanged.
- R8: Offsets at 2G and above, and windows beyond NUM_CPU, read as zero, and writes to them are ignored.
- R9: Read data updates on the clock edge that samples a read request (busSel=1, busWr=0) and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_IRQ | Level-sensitive peripheral interrupt lines, active high |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address: bit 3 is the core window, bits 2:0 are the offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| cpuIrq | output | NUM_CPU | Interrupt request to each core |

## Verification
On every cycle the assertions check the following. A core's request always traces back to an input that was enabled three edges earlier. An all-zero mask forces the request low on the next edge. Status and unmapped writes leave every enable bit unchanged, a write to one window leaves the other window's enables unchanged, and read data is stable outside read cycles. Only the bench scenarios show the rest: the group ordering of offsets, the exact AND of synchronised inputs with each mask as read over the bus, and the cycle-exact rise and fall latency after input and enable changes. The bench covers these with random inputs and masks and with directed timing cases.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int WORD_W  = 32;
  localparam int GRP_W   = 2;   // up to four 32-line groups
  localparam int ADDR_W  = 4;   // window bit plus three offset bits

  typedef struct packed {
    logic             cpu;      // addressed core window
    logic [GRP_W-1:0] grp;      // input group addressed
    logic             enWr;     // write strobe for an enable word
    logic             rdReq;    // read request this cycle
    logic             rdStatus; // read selects a status word
    logic             rdHit;    // read targets a mapped word
  } strobe_t;
endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
  import pirq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam int GROUPS = NUM_IRQ / WORD_W;

  int  offs;
  int  rel;
  logic inWindow;
  logic isEn;
  logic isSt;

  always_comb begin
    offs     = int'(busAddr[2:0]);
    inWindow = (int'(busAddr[3]) < NUM_CPU);
    isEn     = (offs < GROUPS);
    isSt     = (offs >= GROUPS) && (offs < 2 * GROUPS);
    rel      = isEn ? offs : (isSt ? offs - GROUPS : GROUPS - 1);

    stb          = '0;
    stb.cpu      = busAddr[3];
    stb.grp      = GRP_W'(GROUPS - 1 - rel);
    stb.enWr     = busSel && busWr && inWindow && isEn;
    stb.rdReq    = busSel && !busWr;
    stb.rdStatus = isSt;
    stb.rdHit    = inWindow && (isEn || isSt);
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_IRQ-1:0]         irqIn,
  input  strobe_t                    stb,
  input  logic [WORD_W-1:0]          busWdata,
  output logic [WORD_W-1:0]          busRdata,
  output logic [NUM_CPU-1:0]         cpuIrq,
  output logic [NUM_CPU*NUM_IRQ-1:0] enState
);
  localparam int GROUPS = NUM_IRQ / WORD_W;

  logic [NUM_IRQ-1:0] syncA;
  logic [NUM_IRQ-1:0] syncB;
  logic [NUM_IRQ-1:0] enReg  [NUM_CPU];
  logic [NUM_IRQ-1:0] status [NUM_CPU];
  logic [NUM_IRQ-1:0] selVec;
  logic [WORD_W-1:0]  selWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enReg[c] <= '0;
      end else if (stb.enWr && (int'(stb.cpu) == c)) begin
        for (int g = 0; g < GROUPS; g++) begin
          if (int'(stb.grp) == g) enReg[c][g*WORD_W +: WORD_W] <= busWdata;
        end
      end
    end

    assign status[c] = syncB & enReg[c];
    assign enState[c*NUM_IRQ +: NUM_IRQ] = enReg[c];

    always_ff @(posedge clk) begin
      if (!rstN) cpuIrq[c] <= 1'b0;
      else       cpuIrq[c] <= |status[c];
    end
  end

  always_comb begin
    selVec  = '0;
    selWord = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (int'(stb.cpu) == c) selVec = stb.rdStatus ? status[c] : enReg[c];
    end
    for (int g = 0; g < GROUPS; g++) begin
      if (int'(stb.grp) == g) selWord = selVec[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (stb.rdReq) busRdata <= stb.rdHit ? selWord : '0;
  end
endmodule

// File: rtl/pirq_agg.sv
module pirq_agg
  import pirq_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [3:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_CPU-1:0] cpuIrq
);
  strobe_t                    stb;
  logic [NUM_CPU*NUM_IRQ-1:0] enState;

  pirq_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_decode (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  pirq_datapath #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .stb     (stb),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .cpuIrq  (cpuIrq),
    .enState (enState)
  );
endmodule

// File: rtl/pirq_agg_check.sv
module pirq_agg_check #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_IRQ-1:0]         irqIn,
  input logic                       busSel,
  input logic                       busWr,
  input logic [3:0]                 busAddr,
  input logic [31:0]                busRdata,
  input logic [NUM_CPU-1:0]         cpuIrq,
  input logic [NUM_CPU*NUM_IRQ-1:0] enState
);
  localparam int GROUPS = NUM_IRQ / 32;

  logic nonEnWrite;
  assign nonEnWrite = busSel && busWr &&
                      ((int'(busAddr[2:0]) >= GROUPS) || (int'(busAddr[3]) >= NUM_CPU));

  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (enState == '0) && (cpuIrq == '0));

  // Also covers R8: unmapped writes leave the enables alone.
  p_status_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    nonEnWrite |=> $stable(enState));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> $stable(busRdata));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    p_irq_has_source_r5: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrq[c] |-> (($past(irqIn, 3) & $past(enState[c*NUM_IRQ +: NUM_IRQ])) != '0));

    p_mask_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
      (enState[c*NUM_IRQ +: NUM_IRQ] == '0) |=> !cpuIrq[c]);
  end

  if (NUM_CPU == 2) begin : g_iso
    p_cpu_isolate_r7: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && !busAddr[3]) |=> $stable(enState[NUM_IRQ +: NUM_IRQ]));
    p_cpu_isolate_b_r7: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr[3]) |=> $stable(enState[0 +: NUM_IRQ]));
  end
endmodule

bind pirq_agg pirq_agg_check #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_check (
  .clk     (clk),
  .rstN    (rstN),
  .irqIn   (irqIn),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .cpuIrq  (cpuIrq),
  .enState (enState)
);

// File: tb/pirq_agg_test.sv
`timescale 1ns/1ps
module pirq_agg_test;
  localparam int NI = 64;
  localparam int NC = 2;
  localparam int G  = NI / 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NI-1:0] irqIn = '0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [3:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NC-1:0] cpuIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [NI-1:0] enM [NC];

  always #4 clk = ~clk;

  pirq_agg #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .cpuIrq(cpuIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int cpu, input int offs);
    logic [NI-1:0] v;
    if (cpu >= NC || offs >= 2 * G) return 32'h0;
    v = (offs < G) ? enM[cpu] : (irqIn & enM[cpu]);
    return v[(G - 1 - (offs % G)) * 32 +: 32];
  endfunction

  function automatic logic expIrq(input int cpu);
    return |(irqIn & enM[cpu]);
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    if (int'(a[3]) < NC && int'(a[2:0]) < G)
      enM[a[3]][(G - 1 - int'(a[2:0])) * 32 +: 32] = d;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      for (int o = 0; o < 2 * G; o++) begin
        busRead({c[0], o[2:0]}, d);
        check(req, d, expWord(c, o));
      end
      check(req, {31'b0, cpuIrq[c]}, {31'b0, expIrq(c)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++) enM[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 cpuIrq", {30'b0, cpuIrq}, 32'h0);
    irqIn = '1;
    repeat (4) @(negedge clk);
    checkAll("R1 reset reads");

    // R2: readback and group order (offset 0 holds the upper group)
    busWrite(4'h0, 32'hA5A5_0001);
    busWrite(4'h1, 32'h0000_8000);
    irqIn = '0;
    irqIn[32] = 1'b1;
    repeat (4) @(negedge clk);
    busRead(4'h0, d); check("R2 offset0", d, 32'hA5A5_0001);
    busRead(4'h2, d); check("R3 status upper group", d, 32'h0000_0001);
    busRead(4'h3, d); check("R3 status lower group", d, 32'h0);
    check("R5 irq high", {31'b0, cpuIrq[0]}, 32'h1);
    check("R7 other core idle", {31'b0, cpuIrq[1]}, 32'h0);

    // R4: status write ignored
    busWrite(4'h2, 32'hFFFF_FFFF);
    busWrite(4'h3, 32'hFFFF_FFFF);
    checkAll("R4 status write");

    // R8: unmapped offsets
    busWrite(4'h4, 32'hDEAD_BEEF);
    busWrite(4'hF, 32'h1234_5678);
    busRead(4'h4, d); check("R8 unmapped read", d, 32'h0);
    busRead(4'hE, d); check("R8 unmapped read win1", d, 32'h0);
    checkAll("R8 state kept");

    // R6: enable clear drops output on the next edge
    busWrite(4'h0, 32'h0);
    check("R6 still high after write edge", {31'b0, cpuIrq[0]}, 32'h1);
    @(negedge clk);
    check("R6 low one edge later", {31'b0, cpuIrq[0]}, 32'h0);

    // R5/R6: input rise and fall latency
    busWrite(4'h1, 32'h0000_8000);
    irqIn = '0;
    repeat (4) @(negedge clk);
    irqIn[15] = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 not yet after two edges", {31'b0, cpuIrq[0]}, 32'h0);
    @(negedge clk);
    check("R5 high on third edge", {31'b0, cpuIrq[0]}, 32'h1);
    busRead(4'h3, d);
    irqIn[15] = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 still high after two edges", {31'b0, cpuIrq[0]}, 32'h1);
    check("R9 read data held", d, busRdata);
    @(negedge clk);
    check("R6 low on third edge", {31'b0, cpuIrq[0]}, 32'h0);

    // R7: routing to core 1 only
    busWrite(4'h9, 32'h0000_0004);
    irqIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 core1 high", {31'b0, cpuIrq[1]}, 32'h1);
    check("R7 core0 low", {31'b0, cpuIrq[0]}, 32'h0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      irqIn = {$urandom, $urandom};
      for (int k = 0; k < 3; k++) begin
        logic [31:0] w;
        w = (($urandom % 4) == 0) ? 32'h0 : ($urandom & $urandom);
        busWrite(4'($urandom % 16), w);
      end
      repeat (4) @(negedge clk);
      checkAll("R3 R5 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule